// File: doc/BRIEF.md
# Chained Block DMA Pointer Engine

This block moves data between one device and memory in fixed-size blocks, with one transmit channel (memory to device) and one receive channel (device to memory). Each channel keeps an active pointer, which names the block now being transferred, and a standby pointer, which names the block after it. The two blocks may sit at any two addresses. When the active block ends, the channel switches to the standby pointer at once, so the stream has no gap, and it raises a pointer-update status so that software can queue the following block.

Memory traffic uses bursts of one to four 32-bit words. Each burst is staged in a small holding buffer. The device exchanges that buffer's contents as 16-bit halves over a valid/ready handshake. If software has not refilled the standby pointer by the time the next block ends, the channel records an overrun, drops its enable and stops. A single level interrupt is formed from the status bits, each one gated by its own mask bit.

Top module: `dma_ptr_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is 0, `mem_req` is 0 and `dev_tx_valid` is 0.
- R2: Register word indices: 0 holds the transmit active pointer, 1 the transmit standby pointer, 2 the receive active pointer, 3 the receive standby pointer and 4 the control word. Each pointer reads back what was written to it. A write to a standby pointer sets that channel's standby-valid flag: control bit 2 for transmit, bit 3 for receive. `reg_rdata` presents the register chosen by `reg_addr` one clock later.
- R3: Within a block, each completed burst advances the active pointer by BURST_WORDS*4 bytes. Burst addresses are word aligned.
- R4: When a burst ends a block and the standby flag is set, the next burst uses the standby pointer, the standby flag clears, and the pointer-update status is set: control bit 8 for transmit, bit 9 for receive.
- R5: When a burst ends a block and the standby flag is clear, the overrun status is set (bit 10 for transmit, bit 11 for receive). In the same cycle the channel's enable clears (bit 0 for transmit, bit 1 for receive), and no further memory request is made for that channel.
- R6: Status bits 8 to 11 clear only when a 1 is written to them. Writing 0 to them leaves them unchanged. Enable bits 0 and 1 and mask bits 16 to 19 are written directly.
- R7: `irq` goes high one clock after any status bit 8+k (k = 0 to 3) is set while mask bit 16+k is also set. Otherwise `irq` is low.
- R8: A transmit burst reads memory only when the holding buffer is empty. Each 32-bit word goes out to the device as two halves, bits 15:0 first, word 0 first. `dev_tx_data` stays stable while it is stalled.
- R9: A receive burst writes memory only when the holding buffer is full. Incoming halves fill each word low half first, word 0 first. Word j of the burst sits at `mem_wdata[32j+31:32j]`.
- R10: `mem_req` stays high, with a stable address and direction, until `mem_ack` is seen. `mem_we` is 1 for receive writes and 0 for transmit reads.
- R11: A channel whose enable bit is clear makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory burst request |
| mem_we | output | 1 | 1 = write to memory (receive) |
| mem_addr | output | AW | Burst start byte address |
| mem_wdata | output | 32*BURST_WORDS | Burst write data |
| mem_ack | input | 1 | Burst accepted and finished |
| mem_rdata | input | 32*BURST_WORDS | Burst read data, valid with `mem_ack` |
| dev_tx_valid | output | 1 | Transmit half available |
| dev_tx_ready | input | 1 | Device takes transmit half |
| dev_tx_data | output | 16 | Transmit half |
| dev_rx_valid | input | 1 | Device offers receive half |
| dev_rx_ready | output | 1 | Engine accepts receive half |
| dev_rx_data | input | 16 | Receive half |
| irq | output | 1 | Masked status interrupt |

## Verification
The hardest case to reach is the overrun: a block must end while its standby pointer is still unrefilled, and the run must have passed through at least one good chaining step first. Each channel test preloads both pointers and starts the stream with device and memory models that always respond. It waits for the first pointer-update interrupt and refills the standby pointer only once, so the second boundary chains and the third one overruns. The receive test masks the overrun status, which shows that the interrupt is gated by the mask while the sticky bit stays set.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;
  localparam int RA_TX_CUR = 0;
  localparam int RA_TX_NXT = 1;
  localparam int RA_RX_CUR = 2;
  localparam int RA_RX_NXT = 3;
  localparam int RA_CTRL   = 4;
  localparam int NCH       = 2;   // 0 = transmit, 1 = receive
  localparam int NSTS      = 4;   // tx_upd, rx_upd, tx_ovr, rx_ovr
  localparam int B_EN      = 0;
  localparam int B_NVLD    = 2;
  localparam int B_STS     = 8;
  localparam int B_MSK     = 16;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW          = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int BURST_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cur,
  input  logic          wr_nxt,
  input  logic [AW-1:0] wdata,
  input  logic          en,
  input  logic          buf_rdy,
  input  logic          busy,
  input  logic          done,
  output logic          want,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          nxt_vld,
  output logic          upd_hit,
  output logic          ovr_hit
);
  localparam int OFFW = $clog2(BLOCK_BYTES) + 1;
  localparam logic [OFFW-1:0] BB_W  = OFFW'(BURST_BYTES);
  localparam logic [OFFW-1:0] BLK_W = OFFW'(BLOCK_BYTES);

  logic [OFFW-1:0] off_q;
  logic            at_end;

  assign want    = en && buf_rdy && !busy;
  assign at_end  = (off_q + BB_W) >= BLK_W;
  assign upd_hit = done && at_end && nxt_vld;
  assign ovr_hit = done && at_end && !nxt_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      off_q <= '0;
    end else if (wr_cur) begin
      cur   <= wdata;
      off_q <= '0;
    end else if (done) begin
      if (at_end) begin
        off_q <= '0;
        cur   <= nxt_vld ? nxt : cur + AW'(BURST_BYTES);
      end else begin
        off_q <= off_q + BB_W;
        cur   <= cur + AW'(BURST_BYTES);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt     <= '0;
      nxt_vld <= 1'b0;
    end else if (wr_nxt) begin
      nxt     <= wdata;
      nxt_vld <= 1'b1;
    end else if (upd_hit) begin
      nxt_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_tx_buf.sv
module dma_tx_buf #(
  parameter int BURST_WORDS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [32*BURST_WORDS-1:0] load_data,
  output logic                     empty,
  output logic                     dev_valid,
  input  logic                     dev_ready,
  output logic [15:0]              dev_data
);
  localparam int NH = 2 * BURST_WORDS;
  localparam int IW = $clog2(NH);
  localparam logic [IW-1:0] LAST = IW'(NH - 1);

  logic [32*BURST_WORDS-1:0] buf_q;
  logic [IW-1:0]             idx_q;
  logic                      empty_q;

  assign empty     = empty_q;
  assign dev_valid = !empty_q;
  assign dev_data  = buf_q[idx_q*16 +: 16];

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      idx_q   <= '0;
      empty_q <= 1'b1;
    end else if (load) begin
      buf_q   <= load_data;
      idx_q   <= '0;
      empty_q <= 1'b0;
    end else if (!empty_q && dev_ready) begin
      if (idx_q == LAST) begin
        idx_q   <= '0;
        empty_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_rx_buf.sv
module dma_rx_buf #(
  parameter int BURST_WORDS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      drain,
  output logic [32*BURST_WORDS-1:0] data,
  output logic                      full,
  input  logic                      dev_valid,
  output logic                      dev_ready,
  input  logic [15:0]               dev_data
);
  localparam int NH = 2 * BURST_WORDS;
  localparam int IW = $clog2(NH);
  localparam logic [IW-1:0] LAST = IW'(NH - 1);

  logic [32*BURST_WORDS-1:0] buf_q;
  logic [IW-1:0]             idx_q;
  logic                      full_q;

  assign data      = buf_q;
  assign full      = full_q;
  assign dev_ready = !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (drain) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else if (!full_q && dev_valid) begin
      buf_q[idx_q*16 +: 16] <= dev_data;
      if (idx_q == LAST) begin
        idx_q  <= '0;
        full_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_ptr_ctrl.sv
module dma_ptr_ctrl
  import dma_ptr_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int BURST_WORDS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [32*BURST_WORDS-1:0] mem_wdata,
  input  logic                      mem_ack,
  input  logic [32*BURST_WORDS-1:0] mem_rdata,
  output logic                      dev_tx_valid,
  input  logic                      dev_tx_ready,
  output logic [15:0]               dev_tx_data,
  input  logic                      dev_rx_valid,
  output logic                      dev_rx_ready,
  input  logic [15:0]               dev_rx_data,
  output logic                      irq
);
  localparam int BURST_BYTES = 4 * BURST_WORDS;
  localparam int DW          = 32 * BURST_WORDS;

  logic [NCH-1:0]  en_q;
  logic [NSTS-1:0] sts_q, msk_q, sts_set;
  logic [NCH-1:0]  buf_rdy, want, done, upd_hit, ovr_hit, nxt_vld;
  logic [NCH-1:0]  wr_cur, wr_nxt;
  logic [AW-1:0]   cur [NCH];
  logic [AW-1:0]   nxt [NCH];
  logic            busy_q, sel_q;
  logic            tx_empty, rx_full;
  logic [DW-1:0]   rx_data;
  logic            wr_ctrl;

  assign buf_rdy[0] = tx_empty;
  assign buf_rdy[1] = rx_full;
  assign done[0]    = busy_q && mem_ack && !sel_q;
  assign done[1]    = busy_q && mem_ack && sel_q;
  assign wr_ctrl    = reg_we && (reg_addr == 3'(RA_CTRL));

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign wr_cur[c] = reg_we && (reg_addr == 3'(2 * c));
    assign wr_nxt[c] = reg_we && (reg_addr == 3'(2 * c + 1));
    dma_chan #(
      .AW(AW), .BLOCK_BYTES(BLOCK_BYTES), .BURST_BYTES(BURST_BYTES)
    ) u_chan (
      .clk(clk), .rst(rst),
      .wr_cur(wr_cur[c]), .wr_nxt(wr_nxt[c]), .wdata(reg_wdata[AW-1:0]),
      .en(en_q[c]), .buf_rdy(buf_rdy[c]), .busy(busy_q), .done(done[c]),
      .want(want[c]), .cur(cur[c]), .nxt(nxt[c]), .nxt_vld(nxt_vld[c]),
      .upd_hit(upd_hit[c]), .ovr_hit(ovr_hit[c])
    );
  end

  dma_tx_buf #(.BURST_WORDS(BURST_WORDS)) u_txb (
    .clk(clk), .rst(rst), .load(done[0]), .load_data(mem_rdata),
    .empty(tx_empty), .dev_valid(dev_tx_valid), .dev_ready(dev_tx_ready),
    .dev_data(dev_tx_data)
  );

  dma_rx_buf #(.BURST_WORDS(BURST_WORDS)) u_rxb (
    .clk(clk), .rst(rst), .drain(done[1]), .data(rx_data), .full(rx_full),
    .dev_valid(dev_rx_valid), .dev_ready(dev_rx_ready), .dev_data(dev_rx_data)
  );

  // memory port: one burst in flight, transmit served first
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sel_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (!busy_q) begin
      if (want[0]) begin
        busy_q   <= 1'b1;
        sel_q    <= 1'b0;
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= cur[0];
      end else if (want[1]) begin
        busy_q    <= 1'b1;
        sel_q     <= 1'b1;
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= cur[1];
        mem_wdata <= rx_data;
      end
    end else if (mem_ack) begin
      busy_q  <= 1'b0;
      mem_req <= 1'b0;
    end
  end

  assign sts_set = {ovr_hit, upd_hit};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      msk_q <= '0;
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[B_EN +: NCH] & ~ovr_hit;
        msk_q <= reg_wdata[B_MSK +: NSTS];
        sts_q <= (sts_q & ~reg_wdata[B_STS +: NSTS]) | sts_set;
      end else begin
        en_q  <= en_q & ~ovr_hit;
        sts_q <= sts_q | sts_set;
      end
      irq <= |(sts_q & msk_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        3'(RA_TX_CUR): reg_rdata[AW-1:0] <= cur[0];
        3'(RA_TX_NXT): reg_rdata[AW-1:0] <= nxt[0];
        3'(RA_RX_CUR): reg_rdata[AW-1:0] <= cur[1];
        3'(RA_RX_NXT): reg_rdata[AW-1:0] <= nxt[1];
        3'(RA_CTRL): begin
          reg_rdata[B_EN +: NCH]    <= en_q;
          reg_rdata[B_NVLD +: NCH]  <= nxt_vld;
          reg_rdata[B_STS +: NSTS]  <= sts_q;
          reg_rdata[B_MSK +: NSTS]  <= msk_q;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_ptr_ctrl_chk.sv
module dma_ptr_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic [3:0]    sts,
  input logic [3:0]    msk,
  input logic [1:0]    en,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          dev_tx_valid,
  input logic          dev_tx_ready,
  input logic [15:0]   dev_tx_data
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R3
  AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && !mem_we |-> tx_empty); // R8
  AST_RX_FULL_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && mem_we |-> rx_full); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (sts & msk) == 4'b0 |=> !irq); // R7
  AST_TX_OVR_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[2]) |-> !en[0]); // R5
  AST_RX_OVR_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[3]) |-> !en[1]); // R5
  AST_TX_STALL: assert property (@(posedge clk) disable iff (rst)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data)); // R8
endmodule

bind dma_ptr_ctrl dma_ptr_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .irq(irq), .sts(sts_q), .msk(msk_q), .en(en_q),
  .tx_empty(tx_empty), .rx_full(rx_full), .dev_tx_valid(dev_tx_valid),
  .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data)
);

// File: tb/dma_ptr_ctrl_tb_top.sv
module dma_ptr_ctrl_tb_top;
  localparam int BW = 2;
  localparam int DW = 32 * BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2ns clk = ~clk;

  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req, mem_we;
  logic [31:0]   mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          dev_tx_valid;
  logic          dev_tx_ready = 1'b0;
  logic [15:0]   dev_tx_data;
  logic          dev_rx_valid = 1'b0;
  logic          dev_rx_ready;
  logic [15:0]   dev_rx_data = '0;
  logic          irq;

  dma_ptr_ctrl #(.AW(32), .BLOCK_BYTES(16), .BURST_WORDS(BW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_tx_valid(dev_tx_valid),
    .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0]   log_addr [0:31];
  logic          log_we   [0:31];
  logic [DW-1:0] log_wd   [0:31];
  int            nlog = 0;
  logic [15:0]   txh [0:63];
  int            ntxh = 0;
  logic          sink_en = 1'b0;
  logic          src_en = 1'b0;
  logic          will_fire = 1'b0;
  logic [15:0]   seq = '0;

  // memory model, device sink and device source, all driven at the falling edge
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      for (int i = 0; i < BW; i++) mem_rdata[32*i +: 32] = 32'h5500_0000 | (mem_addr + 32'(4*i));
      if (nlog < 32) begin
        log_addr[nlog] = mem_addr;
        log_we[nlog]   = mem_we;
        log_wd[nlog]   = mem_wdata;
      end
      nlog++;
    end else begin
      mem_ack = 1'b0;
    end
    dev_tx_ready = sink_en;
    if (dev_tx_valid && dev_tx_ready) begin
      if (ntxh < 64) txh[ntxh] = dev_tx_data;
      ntxh++;
    end
    if (will_fire) seq = seq + 16'd1;
    dev_rx_data  = 16'hA000 + seq;
    dev_rx_valid = src_en;
    will_fire    = dev_rx_valid && dev_rx_ready;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk(irq, req, 64'(irq), 64'd1);
  endtask

  task automatic wait_ctrl_bit(input int b, input string req);
    logic [31:0] v;
    int n = 0;
    rd(4, v);
    while (!v[b] && n < 2000) begin rd(4, v); n++; end
    chk(v[b], req, 64'(v), 64'(1) << b);
  endtask

  function automatic logic [15:0] tx_half(input logic [31:0] a, input int h);
    logic [31:0] w = 32'h5500_0000 | (a + 32'(4 * (h / 2)));
    return (h % 2 == 0) ? w[15:0] : w[31:16];
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk(!irq && !mem_req && !dev_tx_valid, "R1 outputs", 64'({irq, mem_req, dev_tx_valid}), 64'd0);
    rd(4, v); chk(v == 0, "R1 ctrl", 64'(v), 64'd0);
    rd(0, v); chk(v == 0, "R1 tx_cur", 64'(v), 64'd0);
    rd(3, v); chk(v == 0, "R1 rx_nxt", 64'(v), 64'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(0, 32'h0000_1000); rd(0, v); chk(v == 32'h1000, "R2 tx_cur", 64'(v), 64'h1000);
    wr(1, 32'h0000_2000); rd(1, v); chk(v == 32'h2000, "R2 tx_nxt", 64'(v), 64'h2000);
    wr(2, 32'h0000_4000); rd(2, v); chk(v == 32'h4000, "R2 rx_cur", 64'(v), 64'h4000);
    wr(3, 32'h0000_5000); rd(3, v); chk(v == 32'h5000, "R2 rx_nxt", 64'(v), 64'h5000);
    rd(4, v); chk(v[3:2] == 2'b11, "R2 valid flags", 64'(v[3:2]), 64'd3);
  endtask

  task automatic t_disabled;
    int n0 = nlog;
    sink_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(nlog == n0, "R11 no request while disabled", 64'(nlog), 64'(n0));
  endtask

  task automatic t_tx_chain;
    logic [31:0] v;
    logic [31:0] exp_a [6] = '{32'h1000, 32'h1008, 32'h2000, 32'h2008, 32'h3000, 32'h3008};
    nlog = 0; ntxh = 0;
    wr(4, 32'h0005_0001);
    wait_irq("R4 tx update irq");
    wr(1, 32'h0000_3000);
    wr(4, 32'h0005_0101);
    rd(4, v); chk(v[8] == 1'b0 || v[2] == 1'b0, "R6 tx update cleared", 64'(v), 64'h0);
    wait_ctrl_bit(10, "R5 tx overrun set");
    repeat (60) @(negedge clk);
    chk(nlog == 6, "R5 tx stops after overrun", 64'(nlog), 64'd6);
    for (int i = 0; i < 6; i++) begin
      chk(log_addr[i] == exp_a[i] && !log_we[i], "R3 R4 tx burst address",
          64'({log_we[i], log_addr[i]}), 64'(exp_a[i]));
    end
    chk(ntxh == 24, "R8 tx half count", 64'(ntxh), 64'd24);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] e = tx_half(exp_a[i / 4], i % 4);
      if (txh[i] != e) chk(1'b0, "R8 tx half order", 64'(txh[i]), 64'(e));
    end
    checks++;
    rd(4, v); chk(v[0] == 1'b0, "R5 tx enable cleared", 64'(v), 64'h0);
    chk(irq, "R7 irq with masked-in overrun", 64'(irq), 64'd1);
    wr(4, 32'h0005_0000);
    rd(4, v); chk(v[10] == 1'b1, "R6 write 0 keeps overrun", 64'(v), 64'h400);
    wr(4, 32'h0005_0500);
    rd(4, v); chk(v[11:8] == 4'b0, "R6 W1C clears", 64'(v[11:8]), 64'd0);
    @(negedge clk);
    chk(!irq, "R7 irq low after clear", 64'(irq), 64'd0);
    sink_en = 1'b0;
  endtask

  task automatic t_rx_chain;
    logic [31:0] v;
    logic [31:0] exp_a [6] = '{32'h4000, 32'h4008, 32'h5000, 32'h5008, 32'h6000, 32'h6008};
    nlog = 0;
    src_en = 1'b1;
    wr(4, 32'h0002_0002);
    wait_irq("R4 rx update irq");
    wr(3, 32'h0000_6000);
    wr(4, 32'h0002_0202);
    wait_ctrl_bit(11, "R5 rx overrun set");
    src_en = 1'b0;
    repeat (40) @(negedge clk);
    chk(nlog == 6, "R5 rx stops after overrun", 64'(nlog), 64'd6);
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] e;
      for (int h = 0; h < 2 * BW; h++) e[16*h +: 16] = 16'hA000 + 16'(4 * i + h);
      chk(log_addr[i] == exp_a[i] && log_we[i], "R3 R10 rx burst address",
          64'({log_we[i], log_addr[i]}), 64'(exp_a[i]));
      chk(log_wd[i] == e, "R9 rx packing", 64'(log_wd[i]), 64'(e));
    end
    wr(4, 32'h0002_0200);
    rd(4, v);
    chk(v[11] == 1'b1 && v[1] == 1'b0, "R5 R6 rx overrun sticky, enable off", 64'(v), 64'h0002_0800);
    @(negedge clk);
    chk(!irq, "R7 masked overrun gives no irq", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_disabled();
    t_tx_chain();
    t_rx_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule